// File: doc/BRIEF.md
# Single-Wire Bus Status and FIFO Controller

This block keeps the host-visible status of a single-wire serial bus port that arbitrates by collision. It owns a small receive FIFO, filled by the receive shift register one byte at a time and emptied by host reads. It also owns a small transmit FIFO, filled by host writes and emptied by the transmit bit engine. Around these two queues it keeps seven status flags. It decides when the FIFOs freeze or flush, and it drives a single interrupt request line.

Its inputs are per-symbol events:
- a finished receive byte;
- a received symbol, tagged as a T-sign or as any other symbol;
- the current bus line state;
- the level being driven and the level being sampled, while a frame is being transmitted;
- a wrong-edge error from the receive bit logic.

The host reads the 8-bit status word. It clears the sticky flags through a 4-bit keep mask, in which a 0 clears a flag and a 1 leaves it unchanged.

Top module: `sw_bus_status`

## Requirements
- R1: A receive byte offered while the receive FIFO holds 4 entries is dropped. It sets the data-lost flag, and the FIFO count and contents stay frozen, so the oldest entry is still read first.
- R2: A host read that removes a receive entry clears the data-lost flag on the following cycle, unless an overrun happens in the same cycle.
- R3: The not-empty flag is 1 whenever the receive FIFO holds at least one entry and 0 when it is empty. Entries are read out in arrival order.
- R4: The not-full flag is 1 while the transmit fill level is at most NF_LEVEL (default 3 of 4). It requests an interrupt only in the single cycle after the level drops back to or below the limit, and never merely because the level stays low.
- R5: The telegram-valid flag sets on the second of two consecutive T-sign symbols. Any non-T symbol clears it in hardware, and so does a 0 in host_keep bit 3.
- R6: The protocol-violation flag sets when bus_state enters passive-high (2'b01), leaves passive-high, or enters passive-low (2'b10). Active is 2'b00. Only a 0 in host_keep bit 2 clears the flag.
- R7: The error flag sets when a dominant level is driven while a recessive level is sampled, or when an edge error is reported. Only a 0 in host_keep bit 1 clears it.
- R8: A collision while tx_active is 1 sets both the error and the arbitration-lost flags, pulses tx_abort and empties the transmit FIFO in that cycle.
- R9: While the arbitration-lost flag is 1, host writes to the transmit FIFO are ignored. A 0 in host_keep bit 0 clears the flag, and writes are accepted again afterwards.
- R10: The status bits are, from bit 7 down: data-lost, not-empty, not-full, telegram-valid, protocol-violation, error, arbitration-lost. Bit 0 reads 0. After reset the status word is 8'h20.
- R11: irq is the OR of data-lost, not-empty, the not-full crossing pulse, telegram-valid and protocol-violation. The error and arbitration-lost flags never raise irq.
- R12: If a hardware set and a host clear hit the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_valid | input | 1 | Shift register offers a finished byte |
| rx_byte | input | 8 | Byte from the shift register |
| rx_pop | input | 1 | Host reads one receive entry |
| rx_rdata | output | 8 | Oldest receive entry |
| tx_wr | input | 1 | Host writes one transmit entry |
| tx_wdata | input | 8 | Transmit byte from the host |
| tx_pop | input | 1 | Bit engine takes one transmit entry |
| tx_rdata | output | 8 | Oldest transmit entry |
| tx_empty | output | 1 | Transmit FIFO holds no entry |
| tx_abort | output | 1 | Stop transmission now (collision) |
| tx_active | input | 1 | A frame is being transmitted |
| drv_dominant | input | 1 | Transmitter drives the dominant level |
| smp_recessive | input | 1 | Line is sampled recessive |
| edge_err | input | 1 | Wrong edge inside a received bit |
| sym_valid | input | 1 | A symbol was received |
| sym_is_t | input | 1 | The received symbol is a T-sign |
| bus_state | input | 2 | Line state: 00 active, 01 passive-high, 10 passive-low |
| host_wr | input | 1 | Host writes the keep mask |
| host_keep | input | 4 | 0 clears: bit 3 TV, bit 2 PV, bit 1 ERR, bit 0 ARB |
| status | output | 8 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- an overrun leaves the receive FIFO frozen;
- a flush empties the transmit FIFO;
- writes are refused while arbitration is lost;
- the sticky flags survive everything except their own host clear;
- a non-T symbol drops telegram-valid;
- a collision during transmission raises both error and arbitration-lost;
- a hardware set beats a simultaneous host clear.

Some behaviours show only in the bench's scenarios. These are the ordering of read data after a dropped byte, the single-cycle not-full interrupt pulse and its absence when the level stays low, the exact bus-state transitions that count as protocol violations, and the absence of interrupts from the error flags.

// File: rtl/swb_pkg.sv
package swb_pkg;

  localparam int STAT_W = 8;

  localparam logic [1:0] BUS_ACTIVE  = 2'b00;
  localparam logic [1:0] BUS_PASS_HI = 2'b01;
  localparam logic [1:0] BUS_PASS_LO = 2'b10;

  // Host keep-mask bit positions (0 clears the flag)
  localparam int KEEP_TV  = 3;
  localparam int KEEP_PV  = 2;
  localparam int KEEP_ERR = 1;
  localparam int KEEP_ARB = 0;

  typedef struct packed {
    logic dl;
    logic ne;
    logic nf;
    logic tv;
    logic pv;
    logic err;
    logic arb;
    logic rsv;
  } status_t;

  // Line-state change that counts as a protocol violation
  function automatic logic pv_event(input logic [1:0] prev_s, input logic [1:0] cur_s);
    logic enter_hi, leave_hi, enter_lo;
    enter_hi = (cur_s == BUS_PASS_HI) && (prev_s != BUS_PASS_HI);
    leave_hi = (prev_s == BUS_PASS_HI) && (cur_s != BUS_PASS_HI);
    enter_lo = (cur_s == BUS_PASS_LO) && (prev_s != BUS_PASS_LO);
    return enter_hi || leave_hi || enter_lo;
  endfunction

  // Sticky flag next value: set beats every clear
  function automatic logic flag_next(input logic cur, input logic set_ev, input logic clr_ev);
    return set_ev || (cur && !clr_ev);
  endfunction

endpackage

// File: rtl/swb_fifo.sv
module swb_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_ok) begin
      mem[wr_ptr] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: an offer into a full queue leaves the fill level and head entry unchanged
  a_r1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (full && $stable(dout)));

  // R8: a flush leaves the queue empty
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/swb_flags.sv
module swb_flags
  import swb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_overrun,
  input  logic       rx_pop_ok,
  input  logic       rx_ne,
  input  logic       tx_nf,
  input  logic       sym_valid,
  input  logic       sym_is_t,
  input  logic [1:0] bus_state,
  input  logic       tx_active,
  input  logic       drv_dominant,
  input  logic       smp_recessive,
  input  logic       edge_err,
  input  logic       host_wr,
  input  logic [3:0] host_keep,
  output status_t    status,
  output logic       irq,
  output logic       coll_tx,
  output logic       arb_flag
);
  logic dl_q, tv_q, pv_q, err_q, arb_q;
  logic t_seen_q, nf_prev_q;
  logic [1:0] bus_prev_q;

  // Named internal events
  logic collision, tv_set, tv_hw_clr, pv_set, err_set, nf_pulse;
  logic clr_tv, clr_pv, clr_err, clr_arb;

  assign collision = drv_dominant && smp_recessive;
  assign coll_tx   = collision && tx_active;
  assign tv_set    = sym_valid && sym_is_t && t_seen_q;
  assign tv_hw_clr = sym_valid && !sym_is_t;
  assign pv_set    = pv_event(bus_prev_q, bus_state);
  assign err_set   = collision || edge_err;
  assign nf_pulse  = tx_nf && !nf_prev_q;

  assign clr_tv  = host_wr && !host_keep[KEEP_TV];
  assign clr_pv  = host_wr && !host_keep[KEEP_PV];
  assign clr_err = host_wr && !host_keep[KEEP_ERR];
  assign clr_arb = host_wr && !host_keep[KEEP_ARB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q       <= 1'b0;
      tv_q       <= 1'b0;
      pv_q       <= 1'b0;
      err_q      <= 1'b0;
      arb_q      <= 1'b0;
      t_seen_q   <= 1'b0;
      nf_prev_q  <= 1'b1;
      bus_prev_q <= BUS_ACTIVE;
    end else begin
      dl_q       <= flag_next(dl_q,  rx_overrun, rx_pop_ok);
      tv_q       <= flag_next(tv_q,  tv_set,     tv_hw_clr || clr_tv);
      pv_q       <= flag_next(pv_q,  pv_set,     clr_pv);
      err_q      <= flag_next(err_q, err_set,    clr_err);
      arb_q      <= flag_next(arb_q, coll_tx,    clr_arb);
      nf_prev_q  <= tx_nf;
      bus_prev_q <= bus_state;
      if (sym_valid) t_seen_q <= sym_is_t;
    end
  end

  always_comb begin
    status     = '0;
    status.dl  = dl_q;
    status.ne  = rx_ne;
    status.nf  = tx_nf;
    status.tv  = tv_q;
    status.pv  = pv_q;
    status.err = err_q;
    status.arb = arb_q;
    status.rsv = 1'b0;
  end

  assign irq      = dl_q || rx_ne || nf_pulse || tv_q || pv_q;
  assign arb_flag = arb_q;

  // R2: a successful read without a new overrun drops data-lost
  a_r2_dl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_ok && !rx_overrun) |=> !dl_q);

  // R5: a non-T symbol drops telegram-valid
  a_r5_tv_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_is_t) |=> !tv_q);

  // R6: protocol-violation is held until the host clears it
  a_r6_pv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && !clr_pv) |=> pv_q);

  // R7: error is held until the host clears it
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_err) |=> err_q);

  // R8: a collision while transmitting raises both flags
  a_r8_coll_flags: assert property (@(posedge clk) disable iff (!rst_n)
    coll_tx |=> (arb_q && err_q));

  // R12: a hardware set beats a host clear in the same cycle
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tv_set && clr_tv) |=> tv_q);

endmodule

// File: rtl/sw_bus_status.sv
module sw_bus_status
  import swb_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int DATA_W   = 8,
  parameter int NF_LEVEL = DEPTH - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_byte_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  output logic              tx_empty,
  output logic              tx_abort,
  input  logic              tx_active,
  input  logic              drv_dominant,
  input  logic              smp_recessive,
  input  logic              edge_err,
  input  logic              sym_valid,
  input  logic              sym_is_t,
  input  logic [1:0]        bus_state,
  input  logic              host_wr,
  input  logic [3:0]        host_keep,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] NF_LIM = CW'(NF_LEVEL);

  function automatic logic level_ok(input logic [CW-1:0] cnt);
    return cnt <= NF_LIM;
  endfunction

  logic [CW-1:0] rx_count, tx_count;
  logic rx_full, rx_empty, tx_full;
  logic rx_overrun, rx_pop_ok, tx_push, arb_flag, coll_tx;
  status_t st;

  assign rx_overrun = rx_byte_valid && rx_full;
  assign rx_pop_ok  = rx_pop && !rx_empty;
  assign tx_push    = tx_wr && !arb_flag;
  assign tx_abort   = coll_tx;

  swb_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_byte_valid), .pop(rx_pop), .flush(1'b0),
    .din(rx_byte), .dout(rx_rdata),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  swb_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .pop(tx_pop), .flush(coll_tx),
    .din(tx_wdata), .dout(tx_rdata),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  swb_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .rx_overrun(rx_overrun), .rx_pop_ok(rx_pop_ok),
    .rx_ne(!rx_empty), .tx_nf(level_ok(tx_count)),
    .sym_valid(sym_valid), .sym_is_t(sym_is_t), .bus_state(bus_state),
    .tx_active(tx_active), .drv_dominant(drv_dominant), .smp_recessive(smp_recessive),
    .edge_err(edge_err), .host_wr(host_wr), .host_keep(host_keep),
    .status(st), .irq(irq), .coll_tx(coll_tx), .arb_flag(arb_flag)
  );

  assign status = st;

  // R9: while arbitration is lost a host write does not raise the fill level
  a_r9_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_flag && tx_wr && !tx_pop) |=> (tx_count == $past(tx_count)));

  // R1: the receive fill level never exceeds the depth
  a_r1_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  // R4: the transmit fill level never exceeds the depth, even when full
  a_r4_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && !tx_pop) |=> tx_full);

endmodule

// File: tb/sw_bus_status_tb.sv
`timescale 1ns/1ps
module sw_bus_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_byte_valid = 0, rx_pop = 0, tx_wr = 0, tx_pop = 0;
  logic [7:0] rx_byte = 0, tx_wdata = 0;
  logic tx_active = 0, drv_dominant = 0, smp_recessive = 0, edge_err = 0;
  logic sym_valid = 0, sym_is_t = 0, host_wr = 0;
  logic [1:0] bus_state = 2'b00;
  logic [3:0] host_keep = 4'hF;
  logic [7:0] rx_rdata, tx_rdata, status;
  logic tx_empty, tx_abort, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sw_bus_status u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_empty(tx_empty), .tx_abort(tx_abort), .tx_active(tx_active),
    .drv_dominant(drv_dominant), .smp_recessive(smp_recessive), .edge_err(edge_err),
    .sym_valid(sym_valid), .sym_is_t(sym_is_t), .bus_state(bus_state),
    .host_wr(host_wr), .host_keep(host_keep), .status(status), .irq(irq)
  );

  typedef struct {
    string      tag;
    logic [7:0] st;
    logic       irq;
    bit         rd_en;
    logic [7:0] rd;
    bit         te_en;
    logic       te;
  } exp_t;

  exp_t sb[$];

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare results just after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "status", status, e.st);
      check(e.tag, "irq", {7'd0, irq}, {7'd0, e.irq});
      if (e.rd_en) check(e.tag, "rx_rdata", rx_rdata, e.rd);
      if (e.te_en) check(e.tag, "tx_empty", {7'd0, tx_empty}, {7'd0, e.te});
    end
  end

  // Driver: inputs already set at the falling edge; queue the expectation, then drop pulses
  task automatic step(input string tag, input logic [7:0] st, input logic ir,
                      input bit rd_en = 0, input logic [7:0] rd = 0,
                      input bit te_en = 0, input logic te = 0);
    exp_t e;
    e.tag = tag; e.st = st; e.irq = ir; e.rd_en = rd_en; e.rd = rd; e.te_en = te_en; e.te = te;
    sb.push_back(e);
    @(negedge clk);
    rx_byte_valid = 0; rx_pop = 0; tx_wr = 0; tx_pop = 0;
    tx_active = 0; drv_dominant = 0; smp_recessive = 0; edge_err = 0;
    sym_valid = 0; sym_is_t = 0; host_wr = 0; host_keep = 4'hF;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset status word
    check("R10", "reset status", status, 8'h20);
    check("R11", "reset irq", {7'd0, irq}, 8'd0);

    // R3: fill the receive FIFO
    for (int i = 0; i < 4; i++) begin
      rx_byte_valid = 1; rx_byte = 8'hA1 + 8'(i);
      step("R3", 8'h60, 1'b1, 1, 8'hA1);
    end
    // R1: overrun drops the byte and freezes the queue
    rx_byte_valid = 1; rx_byte = 8'hA5;
    step("R1", 8'hE0, 1'b1, 1, 8'hA1);
    // R2: one read clears data-lost, order preserved
    rx_pop = 1; step("R2", 8'h60, 1'b1, 1, 8'hA2);
    rx_pop = 1; step("R3", 8'h60, 1'b1, 1, 8'hA3);
    rx_pop = 1; step("R1", 8'h60, 1'b1, 1, 8'hA4);
    rx_pop = 1; step("R3", 8'h20, 1'b0);

    // R4: fill transmit FIFO; not-full drops at 4 entries, no interrupt
    tx_wr = 1; tx_wdata = 8'h11; step("R4", 8'h20, 1'b0, 0, 0, 1, 1'b0);
    tx_wr = 1; tx_wdata = 8'h12; step("R4", 8'h20, 1'b0);
    tx_wr = 1; tx_wdata = 8'h13; step("R4", 8'h20, 1'b0);
    tx_wr = 1; tx_wdata = 8'h14; step("R4", 8'h00, 1'b0);
    tx_pop = 1;                  step("R4", 8'h20, 1'b1);
    step("R4", 8'h20, 1'b0);

    // R8: collision while transmitting; R11: no irq from error flags
    tx_active = 1; drv_dominant = 1; smp_recessive = 1;
    step("R8", 8'h26, 1'b0, 0, 0, 1, 1'b1);
    // R9: writes ignored while arbitration lost
    tx_wr = 1; tx_wdata = 8'h55; step("R9", 8'h26, 1'b0, 0, 0, 1, 1'b1);
    host_wr = 1; host_keep = 4'hF; step("R7", 8'h26, 1'b0);
    host_wr = 1; host_keep = 4'h0; step("R9", 8'h20, 1'b0);
    tx_wr = 1; tx_wdata = 8'h56; step("R9", 8'h20, 1'b0, 0, 0, 1, 1'b0);

    // R7: edge error and collision outside transmission set error only
    edge_err = 1; step("R7", 8'h24, 1'b0);
    host_wr = 1; host_keep = 4'b1101; step("R7", 8'h20, 1'b0);
    drv_dominant = 1; smp_recessive = 1; step("R7", 8'h24, 1'b0, 0, 0, 1, 1'b0);
    host_wr = 1; host_keep = 4'b1101; step("R7", 8'h20, 1'b0);

    // R5: telegram-valid
    sym_valid = 1; sym_is_t = 1; step("R5", 8'h20, 1'b0);
    sym_valid = 1; sym_is_t = 1; step("R5", 8'h30, 1'b1);
    sym_valid = 1; sym_is_t = 1; step("R5", 8'h30, 1'b1);
    sym_valid = 1; sym_is_t = 0; step("R5", 8'h20, 1'b0);
    sym_valid = 1; sym_is_t = 1; step("R5", 8'h20, 1'b0);
    sym_valid = 1; sym_is_t = 1; step("R5", 8'h30, 1'b1);
    host_wr = 1; host_keep = 4'b0111; step("R5", 8'h20, 1'b0);
    // R12: set and host clear together leave the flag set
    sym_valid = 1; sym_is_t = 1; host_wr = 1; host_keep = 4'h0; step("R12", 8'h30, 1'b1);
    sym_valid = 1; sym_is_t = 0; step("R5", 8'h20, 1'b0);

    // R6: protocol violations
    bus_state = 2'b01; step("R6", 8'h28, 1'b1);
    host_wr = 1; host_keep = 4'b1011; step("R6", 8'h20, 1'b0);
    bus_state = 2'b00; step("R6", 8'h28, 1'b1);
    host_wr = 1; host_keep = 4'b1011; step("R6", 8'h20, 1'b0);
    bus_state = 2'b10; step("R6", 8'h28, 1'b1);
    host_wr = 1; host_keep = 4'b1011; step("R6", 8'h20, 1'b0);
    bus_state = 2'b00; step("R6", 8'h20, 1'b0);

    @(negedge clk);
    check("R11", "queue drained", 8'(sb.size()), 8'd0);
    finish_run();
  end
endmodule